// File: doc/BRIEF.md
# Toggle-Output PWM Timer with Reload

This block is a 24-bit up-counting timer that draws a periodic waveform on a single output. The output flips when the counter reaches a programmed compare value and flips again when the counter rolls over past its all-ones value. Those two toggles set the duty cycle. The load value sets the period.

A rising edge on `enable` starts the timer. It clears the counter, drives the output to the chosen polarity, and samples the tick source, the compare value and the load value. From then on, the counter advances on timer ticks. The first tick places the load value into the counter, and each later tick adds one. A tick comes either from the system clock divided by two or from an external prescaler strobe.

In reload mode the rollover tick puts the load value straight back into the counter. This gives a period of 0xFFFFFF − load + 1 ticks. Without reload mode the counter wraps through zero. The compare and overflow flags stay set until they are cleared, and each flag is gated by its own interrupt enable. A capture register keeps the count at the last compare match.

Top module: `pwm_toggle_timer`

## Requirements
- R1: A rising edge of `enable` sets `count` to 0 on the next clock. The first timer tick after that loads `count` with the load value, and each later tick increments it.
- R2: With `tick_sel`=0, a tick happens on every second clock while enabled, starting two clocks after the start edge. With `tick_sel`=1, a tick happens on each enabled clock where `presc_tick` is high.
- R3: When a tick puts the compare value into `count`, `pwm_out` toggles, `capture` takes that count, and `cmp_flag` sets.
- R4: A tick while `count` is 0xFFFFFF (and not the first tick) is an overflow. `pwm_out` toggles and `ovf_flag` sets.
- R5: With `reload_mode`=1, the overflow tick loads the load value, so the waveform repeats every 0xFFFFFF − load + 1 ticks. With `reload_mode`=0, the counter wraps to 0 and keeps counting.
- R6: When the timer starts, and on every clock while `enable` is low, `pwm_out` takes the value of `polarity` one clock later.
- R7: `cmp_irq` is high exactly when `cmp_flag` and `cmp_ie` are both high. `ovf_irq` is high exactly when `ovf_flag` and `ovf_ie` are both high.
- R8: Flags stay set until their clear strobe. A set event in the same clock as a clear strobe leaves the flag set.
- R9: While `enable` is low, `count` holds its value and no flag sets.
- R10: `tick_sel`, `cmp_val` and `load_val` are sampled at the start edge. Changing them while running has no effect.
- R11: When compare and overflow fall on the same tick, both flags set and `pwm_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; its rising edge starts the timer |
| polarity | input | 1 | Output level at start and while idle |
| reload_mode | input | 1 | 1: reload on overflow, 0: wrap to zero |
| tick_sel | input | 1 | 0: clock/2 ticks, 1: prescaler ticks |
| presc_tick | input | 1 | Prescaler tick strobe |
| load_val | input | 24 | Value loaded on the first tick and on reload |
| cmp_val | input | 24 | Compare value |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_clr | input | 1 | Clear strobe for the compare flag |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| pwm_out | output | 1 | Waveform output |
| count | output | 24 | Current counter value |
| capture | output | 24 | Count at the last compare match |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Compare interrupt |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that inputs change only between clock edges and that `enable` is a level held for many cycles. They also assume that the clear strobes are single-cycle pulses. The stimulus drives every input one time unit after a falling edge and holds `enable` for whole scenarios.

Load values sit a few counts below 0xFFFFFF, so overflow and reload happen within tens of ticks. Compare values are chosen to land on the first tick, in the middle of the count, and on the overflow tick itself. The prescaler strobe is driven with a random pattern.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned CNT_W_DEF = 24;

  typedef enum logic {
    TICK_DIV2  = 1'b0,
    TICK_PRESC = 1'b1
  } tick_src_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      active,
  input  tick_src_e src,
  input  logic      presc_tick,
  output logic      tick
);
  logic div_q;

  // Divide-by-two phase restarts at every start edge
  always_ff @(posedge clk) begin
    if (rst || start) div_q <= 1'b0;
    else if (active)  div_q <= ~div_q;
  end

  always_comb begin
    if (src == TICK_PRESC) tick = active && presc_tick;
    else                   tick = active && div_q;
  end
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         tick,
  input  logic         reload_mode,
  input  logic [W-1:0] load_v,
  input  logic [W-1:0] cmp_v,
  output logic [W-1:0] count,
  output logic [W-1:0] nxt,
  output logic         cmp_hit,
  output logic         ovf_hit
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] count_q;
  logic         first_q;
  logic         at_top;

  always_comb begin
    at_top = !first_q && (count_q == CNT_MAX);
    if (first_q || (at_top && reload_mode)) nxt = load_v;
    else                                    nxt = count_q + W'(1);
    ovf_hit = tick && at_top;
    cmp_hit = tick && (nxt == cmp_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      first_q <= 1'b0;
    end else if (start) begin
      count_q <= '0;
      first_q <= 1'b1;
    end else if (tick) begin
      count_q <= nxt;
      first_q <= 1'b0;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/pwm_wave_flags.sv
module pwm_wave_flags #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         start,
  input  logic         polarity,
  input  logic         cmp_hit,
  input  logic         ovf_hit,
  input  logic [W-1:0] nxt,
  input  logic         cmp_clr,
  input  logic         ovf_clr,
  output logic         pwm_out,
  output logic [W-1:0] capture,
  output logic         cmp_flag,
  output logic         ovf_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out  <= 1'b0;
      capture  <= '0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      // Two toggles in one tick cancel out
      if (!enable || start)     pwm_out <= polarity;
      else if (cmp_hit ^ ovf_hit) pwm_out <= ~pwm_out;

      if (cmp_hit) capture <= nxt;

      if (cmp_hit)      cmp_flag <= 1'b1;
      else if (cmp_clr) cmp_flag <= 1'b0;

      if (ovf_hit)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             polarity,
  input  logic             reload_mode,
  input  logic             tick_sel,
  input  logic             presc_tick,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cmp_ie,
  input  logic             ovf_ie,
  input  logic             cmp_clr,
  input  logic             ovf_clr,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic             cmp_irq,
  output logic             ovf_irq
);
  logic             en_q;
  logic             start;
  logic             active;
  tick_src_e        src_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cmp_q;
  logic             tick;
  logic [CNT_W-1:0] nxt;
  logic             cmp_hit;
  logic             ovf_hit;

  assign start  = enable && !en_q;
  assign active = enable && en_q;

  // Configuration is taken at the start edge only
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      src_q  <= TICK_DIV2;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      en_q <= enable;
      if (start) begin
        src_q  <= tick_src_e'(tick_sel);
        load_q <= load_val;
        cmp_q  <= cmp_val;
      end
    end
  end

  pwm_tick_gen i_tick (
    .clk(clk), .rst(rst), .start(start), .active(active),
    .src(src_q), .presc_tick(presc_tick), .tick(tick)
  );

  pwm_count_core #(.W(CNT_W)) i_core (
    .clk(clk), .rst(rst), .start(start), .tick(tick),
    .reload_mode(reload_mode), .load_v(load_q), .cmp_v(cmp_q),
    .count(count), .nxt(nxt), .cmp_hit(cmp_hit), .ovf_hit(ovf_hit)
  );

  pwm_wave_flags #(.W(CNT_W)) i_wave (
    .clk(clk), .rst(rst), .enable(enable), .start(start),
    .polarity(polarity), .cmp_hit(cmp_hit), .ovf_hit(ovf_hit), .nxt(nxt),
    .cmp_clr(cmp_clr), .ovf_clr(ovf_clr), .pwm_out(pwm_out),
    .capture(capture), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  assign cmp_irq = cmp_flag && cmp_ie;
  assign ovf_irq = ovf_flag && ovf_ie;
endmodule

// File: rtl/pwm_toggle_timer_chk.sv
module pwm_toggle_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             polarity,
  input logic             cmp_clr,
  input logic             ovf_clr,
  input logic             pwm_out,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture,
  input logic             cmp_flag,
  input logic             ovf_flag
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> count == '0); // R1
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> pwm_out == $past(polarity)); // R6
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !enable |=> pwm_out == $past(polarity)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(count)); // R9
  AST_IDLE_NO_CMP: assert property (@(posedge clk) disable iff (rst)
    (!enable && !cmp_flag) |=> !cmp_flag); // R9
  AST_IDLE_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (!enable && !ovf_flag) |=> !ovf_flag); // R9
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !cmp_clr) |=> cmp_flag); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
  AST_CAPTURE_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(capture) |-> cmp_flag); // R3
endmodule

bind pwm_toggle_timer pwm_toggle_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .enable(enable), .polarity(polarity),
  .cmp_clr(cmp_clr), .ovf_clr(ovf_clr), .pwm_out(pwm_out), .count(count),
  .capture(capture), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
);

// File: tb/test_pwm_toggle_timer.sv
module test_pwm_toggle_timer;
  localparam int W = 24;
  localparam logic [W-1:0] TOP = 24'hFFFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 0, polarity = 0, reload_mode = 0, tick_sel = 0, presc_tick = 0;
  logic [W-1:0] load_val = '0, cmp_val = '0;
  logic cmp_ie = 0, ovf_ie = 0, cmp_clr = 0, ovf_clr = 0;
  logic pwm_out, cmp_flag, ovf_flag, cmp_irq, ovf_irq;
  logic [W-1:0] count, capture;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwm_toggle_timer i_pwm_toggle_timer (
    .clk(clk), .rst(rst), .enable(enable), .polarity(polarity),
    .reload_mode(reload_mode), .tick_sel(tick_sel), .presc_tick(presc_tick),
    .load_val(load_val), .cmp_val(cmp_val), .cmp_ie(cmp_ie), .ovf_ie(ovf_ie),
    .cmp_clr(cmp_clr), .ovf_clr(ovf_clr), .pwm_out(pwm_out), .count(count),
    .capture(capture), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
  );

  // Behavioural reference, advanced on each rising edge
  bit m_run_seen, m_first, m_phase, m_out, m_cf, m_of, m_sel;
  logic [W-1:0] m_cnt, m_cap, m_load, m_cmp;

  always @(posedge clk) begin
    if (rst) begin
      m_run_seen = 0; m_first = 0; m_phase = 0; m_out = 0; m_cf = 0; m_of = 0;
      m_cnt = 0; m_cap = 0; m_sel = 0; m_load = 0; m_cmp = 0;
    end else begin
      bit go, running, tk, top, hc, ho;
      logic [W-1:0] after;
      go = enable && !m_run_seen;
      running = enable && m_run_seen;
      tk = running && (m_sel ? presc_tick : m_phase);
      top = !m_first && m_cnt == TOP;
      if (m_first || (top && reload_mode)) after = m_load;
      else after = m_cnt + 24'd1;
      hc = tk && after == m_cmp;
      ho = tk && top;
      if (!enable || go) m_out = polarity;
      else if (hc != ho) m_out = !m_out;
      if (hc) m_cap = after;
      if (hc) m_cf = 1; else if (cmp_clr) m_cf = 0;
      if (ho) m_of = 1; else if (ovf_clr) m_of = 0;
      if (go) begin
        m_cnt = 0; m_first = 1; m_phase = 0;
        m_sel = tick_sel; m_load = load_val; m_cmp = cmp_val;
      end else begin
        if (tk) begin m_cnt = after; m_first = 0; end
        if (running) m_phase = !m_phase;
      end
      m_run_seen = enable;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "count R1", int'(count), int'(m_cnt));
      chk(cur_req, "pwm_out R6", int'(pwm_out), int'(m_out));
      chk(cur_req, "capture R3", int'(capture), int'(m_cap));
      chk(cur_req, "cmp_flag R8", int'(cmp_flag), int'(m_cf));
      chk(cur_req, "ovf_flag R4", int'(ovf_flag), int'(m_of));
      chk(cur_req, "cmp_irq R7", int'(cmp_irq), int'(m_cf && cmp_ie));
      chk(cur_req, "ovf_irq R7", int'(ovf_irq), int'(m_of && ovf_ie));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1; cmp_clr = 1; ovf_clr = 1;
    @(negedge clk); #1; cmp_clr = 0; ovf_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset count", int'(count), 0);
    chk("R6", "reset out", int'(pwm_out), 0);
    cyc(1);

    // R5 reload mode with compare mid-period
    cur_req = "R5";
    load_val = TOP - 24'd15; cmp_val = TOP - 24'd7; reload_mode = 1;
    cmp_ie = 1; ovf_ie = 1; enable = 1;
    @(negedge clk);
    chk("R1", "count after start", int'(count), 0);
    chk("R6", "out after start", int'(pwm_out), 0);
    while (count != TOP - 24'd15) @(negedge clk);
    n = 0;
    while (count == TOP - 24'd15) begin @(negedge clk); n++; end
    while (count != TOP - 24'd15) begin @(negedge clk); n++; end
    chk("R5", "period clocks", n, 32);
    cyc(100);
    chk("R3", "capture at match", int'(capture), int'(TOP - 24'd7));
    chk("R4", "overflow flag", int'(ovf_flag), 1);
    pulse_clr();
    cur_req = "R8";
    cyc(40);

    // R9 disabled: hold and follow polarity
    cur_req = "R9";
    enable = 0; pulse_clr(); cyc(2);
    n = int'(count);
    polarity = 1; cyc(5);
    chk("R9", "count held", int'(count), n);
    chk("R6", "idle out follows polarity", int'(pwm_out), 1);
    chk("R9", "no flag while idle", int'(cmp_flag | ovf_flag), 0);

    // R5 without reload: wraps through zero, polarity 1
    cur_req = "R5";
    reload_mode = 0; load_val = TOP - 24'd5; cmp_val = TOP - 24'd2;
    enable = 1; cyc(30);
    chk("R5", "wrapped count small", int'(count < 24'd20), 1);
    enable = 0; pulse_clr(); cyc(3);

    // R2 prescaler ticks with random strobe; R10 mid-run changes
    cur_req = "R2";
    tick_sel = 1; reload_mode = 1; polarity = 0;
    load_val = TOP - 24'd9; cmp_val = TOP - 24'd3; enable = 1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); #1; presc_tick = 1'($urandom);
      if (i == 60) begin
        cur_req = "R10";
        tick_sel = 0; load_val = 24'd5; cmp_val = 24'd7;
      end
    end
    presc_tick = 0;
    cyc(4);
    chk("R10", "load still latched", int'(count >= TOP - 24'd9), 1);
    enable = 0; pulse_clr(); cyc(3);

    // R11 compare on the overflow tick (cmp equals reload value)
    cur_req = "R11";
    load_val = TOP - 24'd3; cmp_val = TOP - 24'd3; reload_mode = 1; cmp_ie = 0;
    enable = 1; cyc(60);
    chk("R11", "both flags", int'(cmp_flag & ovf_flag), 1);
    chk("R7", "cmp irq masked", int'(cmp_irq), 0);
    enable = 0; pulse_clr(); cyc(3);
    reload_mode = 0; cmp_val = 24'd0; load_val = TOP - 24'd2; enable = 1;
    cyc(20);
    chk("R11", "zero compare both flags", int'(cmp_flag & ovf_flag), 1);
    enable = 0; cyc(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule